// File: doc/BRIEF.md
# Single-Channel Memory/Device Transfer Engine

This block moves a run of 32-bit words between one I/O device port and system memory so that the processor does not have to. Software first loads a source address, a destination address and a byte count through a small word-indexed register port. It then writes a control word that holds the transfer direction, a device identity and a start bit. The engine asks for the memory bus and waits for the grant. After that it runs as bus master. It produces every word address itself and steps by four bytes per word. It moves a word only when the device side is ready for it.

There is a single interrupt line. It rises when the whole run has finished, or when the run stops because of a bad setup or a memory fault. It never rises once per word. After the interrupt, software reads the status word to learn whether the run succeeded. If it failed, software can also read the faulting address and the number of bytes left unmoved. A word written to the status register clears the done and error flags for each bit set in it. The latched direction and device identity can be read back at any time.

Top module: `dma_ctrl`

## Requirements
- R1: After reset the status word reads 0, the remaining count reads 0, and `irq`, `bus_req` and `mem_req` are low.
- R2: Register indices on `cfg_addr` are 0 control, 1 source, 2 destination, 3 byte count, 4 status, 5 fault address and 6 remaining bytes. Control bit 0 is start (it reads back 0), bit 1 is the direction (0 moves device to memory, 1 moves memory to device) and bits 15:8 hold the device identity. Status bit 0 is busy, bit 1 is done, bit 2 is error and bit 3 is setup fault. `cfg_rdata` shows the register selected at the previous clock edge.
- R3: After a valid start, `bus_req` rises. No `mem_req` occurs until `bus_grant` has been seen while `bus_req` was high. `bus_req` falls in the cycle in which the run finishes or aborts.
- R4: In device-to-memory mode, each word is taken from `dev_in_data` in a cycle where `dev_in_valid` and `dev_in_ready` are both high. It is then written (`mem_we`=1) to the destination address, and the address rises by 4 per word. `dev_sel` shows the device identity latched at start.
- R5: In memory-to-device mode, each word is read (`mem_we`=0) from the source address, which rises by 4 per word. The word is offered on `dev_out_data` with `dev_out_valid` until `dev_out_ready` accepts it.
- R6: A start whose byte count is zero or not a multiple of 4 never raises `bus_req`. It sets error and setup fault (status 0xC) and raises `irq` on the clock edge that takes the write.
- R7: If `mem_err` is returned on an access, the run aborts. The status word becomes 0x4, the fault register holds the failing address, the remaining count still includes the failing word, and in the next cycle `bus_req` is low and `irq` is high.
- R8: `irq` stays low while a run is busy and rises in the cycle after the final word transfer. A successful run leaves status 0x2 and a remaining count of 0.
- R9: A status write with bit 1 set clears done, and one with bit 2 set clears error and setup fault. `irq` is low once neither done nor error is set.
- R10: While busy, a start write is ignored, and writes to control, source, destination and count do not change their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| irq | output | 1 | Completion or error interrupt, level |
| bus_req | output | 1 | Memory bus request |
| bus_grant | input | 1 | Memory bus grant |
| mem_req | output | 1 | Memory access valid, held until ack or error |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| dev_sel | output | 8 | Device identity of the current or last run |
| dev_in_valid | input | 1 | Device has a word for memory |
| dev_in_data | input | 32 | Word from device |
| dev_in_ready | output | 1 | Engine takes the device word this cycle |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_data | output | 32 | Word to device |
| dev_out_ready | input | 1 | Device accepts the offered word |

## Verification
The hardest case to reach from the ports is a register write that arrives while a run is in flight. Such a write must not disturb the latched addresses or the direction, so the bench holds back the bus grant for several cycles and stalls the device. This keeps the engine parked in its request phase while a second start and a new source address are written. The engine must then finish the first run unchanged. Memory faults at the first and at a middle word are injected by address match, and their timing is checked against the remaining-byte count and the release of `bus_req` in the following cycle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] RIDX_CTRL   = 3'd0;
  localparam logic [REG_IDX_W-1:0] RIDX_SRC    = 3'd1;
  localparam logic [REG_IDX_W-1:0] RIDX_DST    = 3'd2;
  localparam logic [REG_IDX_W-1:0] RIDX_COUNT  = 3'd3;
  localparam logic [REG_IDX_W-1:0] RIDX_STATUS = 3'd4;
  localparam logic [REG_IDX_W-1:0] RIDX_FAULT  = 3'd5;
  localparam logic [REG_IDX_W-1:0] RIDX_REMAIN = 3'd6;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DIR_BIT   = 1;
  localparam int CTRL_ID_LSB    = 8;

  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_ERR_BIT   = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_DIN,
    S_MWR,
    S_MRD,
    S_DOUT
  } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int ID_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [REG_IDX_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic                 busy,
  input  logic                 fin_ok,
  input  logic                 fin_err,
  input  logic                 fin_setup,
  input  logic [ADDR_W-1:0]    fault_addr,
  input  logic [CNT_W-1:0]     remain,
  output logic                 start,
  output logic                 start_dir,
  output logic [ID_W-1:0]      start_id,
  output logic [ADDR_W-1:0]    src_q,
  output logic [ADDR_W-1:0]    dst_q,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 irq
);
  logic            dir_q;
  logic [ID_W-1:0] id_q;
  logic            done_q, err_q, setup_q;
  logic            wr_open;

  assign wr_open   = cfg_we && !busy;
  assign start     = wr_open && (cfg_addr == RIDX_CTRL) && cfg_wdata[CTRL_START_BIT];
  assign start_dir = cfg_wdata[CTRL_DIR_BIT];
  assign start_id  = cfg_wdata[CTRL_ID_LSB +: ID_W];
  assign irq       = done_q | err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= 1'b0;
      id_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      setup_q <= 1'b0;
    end else begin
      if (wr_open) begin
        case (cfg_addr)
          RIDX_CTRL: begin
            dir_q <= cfg_wdata[CTRL_DIR_BIT];
            id_q  <= cfg_wdata[CTRL_ID_LSB +: ID_W];
          end
          RIDX_SRC:   src_q <= cfg_wdata[ADDR_W-1:0];
          RIDX_DST:   dst_q <= cfg_wdata[ADDR_W-1:0];
          RIDX_COUNT: cnt_q <= cfg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (start) begin
        done_q  <= 1'b0;
        err_q   <= 1'b0;
        setup_q <= 1'b0;
      end
      if (cfg_we && cfg_addr == RIDX_STATUS) begin
        if (cfg_wdata[STAT_DONE_BIT]) done_q <= 1'b0;
        if (cfg_wdata[STAT_ERR_BIT]) begin
          err_q   <= 1'b0;
          setup_q <= 1'b0;
        end
      end
      if (fin_ok) done_q <= 1'b1;
      if (fin_err) begin
        err_q   <= 1'b1;
        setup_q <= fin_setup;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RIDX_CTRL:   cfg_rdata <= DATA_W'({id_q, 6'b0, dir_q, 1'b0});
        RIDX_SRC:    cfg_rdata <= DATA_W'(src_q);
        RIDX_DST:    cfg_rdata <= DATA_W'(dst_q);
        RIDX_COUNT:  cfg_rdata <= DATA_W'(cnt_q);
        RIDX_STATUS: cfg_rdata <= DATA_W'({setup_q, err_q, done_q, busy});
        RIDX_FAULT:  cfg_rdata <= DATA_W'(fault_addr);
        RIDX_REMAIN: cfg_rdata <= DATA_W'(remain);
        default:     cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_dir,
  input  logic [ID_W-1:0]   start_id,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic              busy,
  output logic              xfer_dir,
  output logic              fin_ok,
  output logic              fin_err,
  output logic              fin_setup,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [CNT_W-1:0]  remain,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic [ID_W-1:0]   dev_sel,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready
);
  localparam int              BYTES   = DATA_W / 8;
  localparam int              ALIGN_W = $clog2(BYTES);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(BYTES);
  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(BYTES);

  dma_state_e        state;
  logic [ADDR_W-1:0] src_a, dst_a, fault_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] buf_q;
  logic [ID_W-1:0]   id_q;
  logic              dir_q;
  logic              bad_cnt, last;

  assign bad_cnt  = (cfg_cnt == '0) || (|cfg_cnt[ALIGN_W-1:0]);
  assign last     = (rem_q == CSTEP);

  assign bus_req       = (state != S_IDLE);
  assign busy          = bus_req;
  assign mem_req       = (state == S_MWR) || (state == S_MRD);
  assign mem_we        = (state == S_MWR);
  assign mem_addr      = (state == S_MWR) ? dst_a : src_a;
  assign mem_wdata     = buf_q;
  assign dev_in_ready  = (state == S_DIN);
  assign dev_out_valid = (state == S_DOUT);
  assign dev_out_data  = buf_q;
  assign dev_sel       = id_q;
  assign xfer_dir      = dir_q;
  assign fault_addr    = fault_q;
  assign remain        = rem_q;

  assign fin_setup = (state == S_IDLE) && start && bad_cnt;
  assign fin_err   = fin_setup || (mem_req && mem_err);
  assign fin_ok    = last && (((state == S_MWR) && mem_ack && !mem_err) ||
                              ((state == S_DOUT) && dev_out_ready));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      src_a   <= '0;
      dst_a   <= '0;
      fault_q <= '0;
      rem_q   <= '0;
      buf_q   <= '0;
      id_q    <= '0;
      dir_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start && !bad_cnt) begin
          src_a <= cfg_src;
          dst_a <= cfg_dst;
          rem_q <= cfg_cnt;
          dir_q <= start_dir;
          id_q  <= start_id;
          state <= S_REQ;
        end
        S_REQ: if (bus_grant) state <= dir_q ? S_MRD : S_DIN;
        S_DIN: if (dev_in_valid) begin
          buf_q <= dev_in_data;
          state <= S_MWR;
        end
        S_MWR: if (mem_err) begin
          fault_q <= dst_a;
          state   <= S_IDLE;
        end else if (mem_ack) begin
          dst_a <= dst_a + ASTEP;
          rem_q <= rem_q - CSTEP;
          state <= last ? S_IDLE : S_DIN;
        end
        S_MRD: if (mem_err) begin
          fault_q <= src_a;
          state   <= S_IDLE;
        end else if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_DOUT;
        end
        S_DOUT: if (dev_out_ready) begin
          src_a <= src_a + ASTEP;
          rem_q <= rem_q - CSTEP;
          state <= last ? S_IDLE : S_MRD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int ID_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [REG_IDX_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 irq,
  output logic                 bus_req,
  input  logic                 bus_grant,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  output logic [ID_W-1:0]      dev_sel,
  input  logic                 dev_in_valid,
  input  logic [DATA_W-1:0]    dev_in_data,
  output logic                 dev_in_ready,
  output logic                 dev_out_valid,
  output logic [DATA_W-1:0]    dev_out_data,
  input  logic                 dev_out_ready
);
  logic              busy, xfer_dir;
  logic              fin_ok, fin_err, fin_setup;
  logic              start, start_dir;
  logic [ID_W-1:0]   start_id;
  logic [ADDR_W-1:0] src_q, dst_q, fault_addr;
  logic [CNT_W-1:0]  cnt_q, remain;

  dma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .fin_ok(fin_ok), .fin_err(fin_err), .fin_setup(fin_setup),
    .fault_addr(fault_addr), .remain(remain),
    .start(start), .start_dir(start_dir), .start_id(start_id),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .irq(irq)
  );

  dma_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_eng (
    .clk(clk), .rst(rst),
    .start(start), .start_dir(start_dir), .start_id(start_id),
    .cfg_src(src_q), .cfg_dst(dst_q), .cfg_cnt(cnt_q),
    .busy(busy), .xfer_dir(xfer_dir),
    .fin_ok(fin_ok), .fin_err(fin_err), .fin_setup(fin_setup),
    .fault_addr(fault_addr), .remain(remain),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .dev_sel(dev_sel),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic bus_req,
  input logic bus_grant,
  input logic mem_req,
  input logic mem_we,
  input logic mem_err,
  input logic irq,
  input logic busy,
  input logic dev_in_ready,
  input logic dev_out_valid,
  input logic xfer_dir
);
  logic granted;

  always_ff @(posedge clk) begin
    if (rst)           granted <= 1'b0;
    else if (!bus_req) granted <= 1'b0;
    else if (bus_grant) granted <= 1'b1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> bus_req); // R3
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> granted); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !irq); // R8
  AST_IN_DIR: assert property (@(posedge clk) disable iff (rst)
    dev_in_ready |-> !xfer_dir); // R4
  AST_WE_DIR: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_we == !xfer_dir)); // R4
  AST_OUT_DIR: assert property (@(posedge clk) disable iff (rst)
    dev_out_valid |-> xfer_dir); // R5
  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_err) |=> (!bus_req && irq)); // R7
endmodule

bind dma_ctrl dma_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_grant(bus_grant),
  .mem_req(mem_req), .mem_we(mem_we), .mem_err(mem_err), .irq(irq),
  .busy(busy), .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
  .xfer_dir(xfer_dir)
);

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;
  import dma_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq, bus_req, mem_req, mem_we;
  logic        bus_grant = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [7:0]  dev_sel;
  logic        dev_in_valid = 1'b0;
  logic [31:0] dev_in_data = '0;
  logic        dev_in_ready, dev_out_valid;
  logic [31:0] dev_out_data;
  logic        dev_out_ready = 1'b0;

  always #5 clk = ~clk;

  dma_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .dev_sel(dev_sel),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wd = 0;

  logic [31:0] exp_addr_q[$];
  logic [31:0] din_q[$];
  logic [31:0] dout_got[$];
  logic [31:0] mem_m[logic [31:0]];
  bit          exp_we, din_pend, grant_seen, op_active, end_pend, err_en;
  logic [31:0] err_at;
  int          grant_delay, gcnt, mem_lat, mcnt, stall_mod, out_stall_mod, out_expect;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  // reference model of bus, memory and device, evaluated between edges
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (end_pend) begin
        chk("R8", {31'b0, irq}, 32'd1, "irq in cycle after finish");
        chk("R3", {31'b0, bus_req}, 32'd0, "bus_req released at finish");
        end_pend = 0;
        op_active = 0;
      end else if (op_active) begin
        chk("R8", {31'b0, irq}, 32'd0, "irq quiet while running");
      end
      if (!bus_req) begin
        bus_grant = 0; gcnt = 0; grant_seen = 0;
      end else begin
        if (bus_grant) grant_seen = 1;
        if (gcnt >= grant_delay) bus_grant = 1;
        else gcnt++;
      end
      if (mem_ack || mem_err) begin
        mem_ack = 0; mem_err = 0; mcnt = 0;
      end else if (mem_req) begin
        chk("R3", {31'b0, grant_seen}, 32'd1, "access only after grant");
        if (mcnt < mem_lat) mcnt++;
        else begin
          if (exp_addr_q.size() == 0) begin
            chk("R4", 32'd1, 32'd0, "unexpected memory access");
          end else begin
            chk(exp_we ? "R4" : "R5", mem_addr, exp_addr_q[0], "access address");
            chk(exp_we ? "R4" : "R5", {31'b0, mem_we}, {31'b0, exp_we}, "access direction");
            void'(exp_addr_q.pop_front());
          end
          if (err_en && mem_addr == err_at) begin
            mem_err = 1;
            exp_addr_q.delete();
            end_pend = 1;
          end else begin
            mem_ack = 1;
            if (mem_we) mem_m[mem_addr] = mem_wdata;
            else mem_rdata = mem_rd(mem_addr);
            if (mem_we && exp_addr_q.size() == 0) end_pend = 1;
          end
        end
      end
      if (din_pend) begin
        void'(din_q.pop_front());
        din_pend = 0;
      end
      dev_in_valid = (din_q.size() > 0) && (stall_mod == 0 || (cyc % stall_mod) != 0);
      dev_in_data  = (din_q.size() > 0) ? din_q[0] : 32'h0;
      if (dev_in_valid && dev_in_ready) din_pend = 1;
      dev_out_ready = (out_stall_mod == 0) || ((cyc % out_stall_mod) != 0);
      if (dev_out_valid && dev_out_ready) begin
        dout_got.push_back(dev_out_data);
        if (dout_got.size() == out_expect) end_pend = 1;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic launch(input bit m2d, input logic [7:0] id, input logic [31:0] src,
                        input logic [31:0] dst, input int nw, input logic [31:0] base);
    exp_addr_q.delete(); din_q.delete(); dout_got.delete(); din_pend = 0;
    exp_we = !m2d;
    out_expect = m2d ? nw : -1;
    for (int i = 0; i < nw; i++) begin
      exp_addr_q.push_back((m2d ? src : dst) + 32'(4 * i));
      if (m2d) mem_m[src + 32'(4 * i)] = base + 32'(i);
      else din_q.push_back(base + 32'(i));
    end
    wr(RIDX_SRC, src);
    wr(RIDX_DST, dst);
    wr(RIDX_COUNT, 32'(4 * nw));
    op_active = 1;
    wr(RIDX_CTRL, {16'h0, id, 6'h0, m2d, 1'b1});
  endtask

  task automatic wait_end();
    while (op_active) @(negedge clk);
    @(negedge clk);
    din_q.delete(); din_pend = 0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", wd);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    grant_delay = 0; mem_lat = 0; stall_mod = 0; out_stall_mod = 0; out_expect = -1;
    err_en = 0; err_at = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'b0, irq}, 0, "irq after reset");
    chk("R1", {31'b0, bus_req}, 0, "bus_req after reset");
    chk("R1", {31'b0, mem_req}, 0, "mem_req after reset");
    rd(RIDX_STATUS, v); chk("R1", v, 0, "status after reset");
    rd(RIDX_REMAIN, v); chk("R1", v, 0, "remaining after reset");

    // R4 device to memory, delayed grant, stalled device
    grant_delay = 4; mem_lat = 1; stall_mod = 3;
    launch(0, 8'h3C, 32'h0, 32'h100, 4, 32'hA000_0000);
    wait_end();
    for (int i = 0; i < 4; i++)
      chk("R4", mem_rd(32'h100 + 32'(4 * i)), 32'hA000_0000 + 32'(i), "word in memory");
    chk("R4", {24'h0, dev_sel}, 32'h3C, "device identity");
    rd(RIDX_STATUS, v); chk("R8", v, 32'h2, "status after success");
    rd(RIDX_REMAIN, v); chk("R8", v, 0, "remaining after success");
    rd(RIDX_CTRL, v);   chk("R2", v, 32'h3C00, "control readback");
    rd(RIDX_DST, v);    chk("R2", v, 32'h100, "destination readback");
    wr(RIDX_STATUS, 32'h2);
    chk("R9", {31'b0, irq}, 0, "irq after clearing done");
    rd(RIDX_STATUS, v); chk("R9", v, 0, "status after clearing done");

    // R5 memory to device with read latency and device backpressure
    grant_delay = 0; mem_lat = 2; stall_mod = 0; out_stall_mod = 2;
    launch(1, 8'h07, 32'h200, 32'h0, 5, 32'hB000_0000);
    wait_end();
    chk("R5", 32'(dout_got.size()), 5, "words delivered");
    for (int i = 0; i < 5 && i < dout_got.size(); i++)
      chk("R5", dout_got[i], 32'hB000_0000 + 32'(i), "word to device");
    rd(RIDX_STATUS, v); chk("R8", v, 32'h2, "status after read run");
    rd(RIDX_CTRL, v);   chk("R2", v, 32'h0702, "control readback direction");
    wr(RIDX_STATUS, 32'h2);
    out_stall_mod = 0;

    // R6 unaligned and zero counts
    wr(RIDX_COUNT, 32'd6);
    wr(RIDX_CTRL, 32'h1);
    chk("R6", {31'b0, irq}, 1, "irq on unaligned count");
    chk("R6", {31'b0, bus_req}, 0, "no request on unaligned count");
    repeat (3) @(negedge clk);
    chk("R6", {31'b0, bus_req}, 0, "still no request");
    rd(RIDX_STATUS, v); chk("R6", v, 32'hC, "status setup fault");
    wr(RIDX_STATUS, 32'h4);
    chk("R9", {31'b0, irq}, 0, "irq after clearing error");
    rd(RIDX_STATUS, v); chk("R9", v, 0, "status after clearing error");
    wr(RIDX_COUNT, 32'd0);
    wr(RIDX_CTRL, 32'h1);
    chk("R6", {31'b0, irq}, 1, "irq on zero count");
    rd(RIDX_STATUS, v); chk("R6", v, 32'hC, "status zero count");
    wr(RIDX_STATUS, 32'h4);

    // R7 memory fault on third write word
    err_en = 1; err_at = 32'h308; mem_lat = 0;
    launch(0, 8'h21, 32'h0, 32'h300, 4, 32'hC000_0000);
    wait_end();
    rd(RIDX_STATUS, v); chk("R7", v, 32'h4, "status after write fault");
    rd(RIDX_FAULT, v);  chk("R7", v, 32'h308, "fault address");
    rd(RIDX_REMAIN, v); chk("R7", v, 32'd8, "remaining after write fault");
    chk("R7", mem_rd(32'h304), 32'hC000_0001, "word before fault written");
    chk("R7", {31'b0, mem_m.exists(32'h308)}, 0, "faulting word not stored");
    wr(RIDX_STATUS, 32'h4);

    // R7 memory fault on first read word
    err_at = 32'h400;
    launch(1, 8'h22, 32'h400, 32'h0, 4, 32'hD000_0000);
    wait_end();
    rd(RIDX_STATUS, v); chk("R7", v, 32'h4, "status after read fault");
    rd(RIDX_FAULT, v);  chk("R7", v, 32'h400, "fault address first word");
    rd(RIDX_REMAIN, v); chk("R7", v, 32'd16, "remaining after first-word fault");
    chk("R7", 32'(dout_got.size()), 0, "nothing delivered");
    wr(RIDX_STATUS, 32'h4);
    err_en = 0;

    // R10 writes during a run
    grant_delay = 8; stall_mod = 4;
    launch(0, 8'h11, 32'h0, 32'h500, 3, 32'hE000_0000);
    wr(RIDX_SRC, 32'hDEAD_0000);
    wr(RIDX_CTRL, 32'h5503);
    rd(RIDX_STATUS, v); chk("R2", v, 32'h1, "busy bit while running");
    wait_end();
    for (int i = 0; i < 3; i++)
      chk("R10", mem_rd(32'h500 + 32'(4 * i)), 32'hE000_0000 + 32'(i), "run unaffected");
    rd(RIDX_CTRL, v); chk("R10", v, 32'h1100, "control kept");
    rd(RIDX_SRC, v);  chk("R10", v, 32'h0, "source kept");
    rd(RIDX_STATUS, v); chk("R10", v, 32'h2, "single completion");
    chk("R10", {31'b0, bus_req}, 0, "ignored start left idle");

    summary();
    $finish;
  end
endmodule